// File: doc/BRIEF.md
# Device Capability Register Window

This block is a read-only window of memory-mapped registers. It describes how a device's register sets are laid out. Host software reads a header at offset zero, which gives the number of capability records. It then walks the records. Each record names a register set by its identifier and gives the set's offset and length in the window. Three sets are described:

- a device-status set, which holds a per-log event availability field;
- a mailbox set, whose registers belong to a separate block and read as zero here;
- a memory-device set, which returns one fixed status word.

The host reaches the window over a simple 64-bit register bus. Each request carries a word address and byte enables, and each request gets one registered response on the next cycle. Other logic in the device reports whether each event log holds entries through a one-cycle update port. The host sees the result as a bit field in the device-status set.

The window's extent is the end of its last register set, rounded up to a power of two. That rounded extent sets the width of the address port. All host writes complete normally and change nothing.

Top module: `capwin_top`

## Requirements
- R1: The word at offset 0x000 is the array header: identifier 0 in bits [15:0], version 1 in bits [23:16], record count 3 in bits [47:32], all other bits zero (value 0x0000_0003_0001_0000).
- R2: Record k (k = 1..3) occupies offsets 0x10·k to 0x10·k+0xF. Its identifier is in bits [15:0], its version in bits [23:16], its set offset in bits [63:32] and its set length in bits [95:64]. Records 1, 2 and 3 carry identifiers 0x0001 (device status, version 2, offset 0x100, length 0x100), 0x0002 (mailbox, version 1, offset 0x200, length 0x200) and 0x4000 (memory device, version 1, offset 0x400, length 0x20).
- R3: The address port spans the power-of-two aperture 0x800. Reads of unused offsets, including the mailbox set and everything above the memory-device set, return zero with no error.
- R4: A write to any offset gets a response with data zero and no error, and it changes no register. Later reads of the header, the event field and the memory-device word return the values they had before the write.
- R5: Every aligned read inside the memory-device set (0x400 to 0x41F) returns the same word 0x24. In that word, media status is 1 in bits [3:2] and mailbox-ready is 1 in bit 5.
- R6: The event field occupies bits [NUM_LOGS-1:0] of the word at 0x100, one bit per log index. An update with has-entries 1 sets the bit of the named log. An update with has-entries 0 clears it. Other bits are unchanged, and a read issued on the cycle after the update sees the new value.
- R7: After reset every event bit is zero.
- R8: A read returns the addressed word with every byte lane whose enable is low forced to zero.
- R9: A request is refused, with error 1 and data zero, unless its address bits [2:0] are zero and its byte enables form one aligned group: a single lane, a lane pair starting at lane 0, 2, 4 or 6, lanes 0–3, lanes 4–7, or all eight lanes.
- R10: Each request accepted on a clock edge produces exactly one response, valid on the next cycle. The response valid stays low on cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 for a write (dropped), 0 for a read |
| req_addr | input | 11 | Byte address; must be 8-byte aligned |
| req_be | input | 8 | Byte-lane enables of the 64-bit word |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request refused as misaligned |
| rsp_data | output | 64 | Read data, lanes not enabled forced to zero |
| evt_valid | input | 1 | Event availability update present |
| evt_log | input | 2 | Index of the event log being updated |
| evt_has | input | 1 | 1 if that log now holds entries, 0 if empty |

## Verification
The bench goes after the record fields that sit above bit 63, in the second word of each record. A design that packed a record into one word would return zero or the offset where the length belongs. It also issues byte-enable shapes that are contiguous but misaligned, such as lanes 1–2 or lanes 2–5. A design that only checked for contiguity would return data for these instead of refusing them.

Event updates are set and cleared on different logs in sequence. A design that overwrote the whole field, or updated it a cycle late, would show the wrong bit pattern on the very next read. Writes aimed at the event word and the header are followed by reads. A design that let a write land would then return the written pattern.

// File: rtl/capwin_pkg.sv
package capwin_pkg;

    localparam int unsigned DW = 64;
    localparam int unsigned NB = DW / 8;

    // memory-device status word layout
    localparam int unsigned MEDIA_LSB = 2;
    localparam int unsigned READY_BIT = 5;
    localparam logic [DW-1:0] MEMDEV_WORD =
        (64'd1 << MEDIA_LSB) | (64'd1 << READY_BIT);

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [DW-1:0] data;
    } rsp_t;

    // aligned lane groups: one lane, pairs on even lanes, halves, whole word
    function automatic logic be_aligned(input logic [NB-1:0] be);
        logic ok;
        ok = 1'b0;
        for (int w = 1; w <= NB; w = w * 2) begin
            for (int s = 0; s < NB; s = s + w) begin
                if (be == NB'(((1 << w) - 1) << s)) ok = 1'b1;
            end
        end
        return ok;
    endfunction

    function automatic logic [DW-1:0] be_mask(input logic [NB-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < NB; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/capwin_rom.sv
module capwin_rom #(
    parameter int unsigned CAP_LEN = 32'h80,
    parameter int unsigned DEV_OFF = 32'h100,
    parameter int unsigned DEV_LEN = 32'h100,
    parameter int unsigned DEV_VER = 2,
    parameter int unsigned MBX_OFF = 32'h200,
    parameter int unsigned MBX_LEN = 32'h200,
    parameter int unsigned MBX_VER = 1,
    parameter int unsigned MEM_OFF = 32'h400,
    parameter int unsigned MEM_LEN = 32'h20,
    parameter int unsigned MEM_VER = 1,
    localparam int unsigned IW = $clog2(CAP_LEN / 8)
) (
    input  logic [IW-1:0] word_idx,
    output logic [63:0]   word
);
    localparam int unsigned NREC = 3;
    localparam int unsigned SW   = $clog2(NREC + 1);

    localparam logic [15:0] REC_ID  [NREC] = '{16'h0001, 16'h0002, 16'h4000};
    localparam logic [7:0]  REC_VER [NREC] = '{8'(DEV_VER), 8'(MBX_VER), 8'(MEM_VER)};
    localparam logic [31:0] REC_OFF [NREC] = '{DEV_OFF, MBX_OFF, MEM_OFF};
    localparam logic [31:0] REC_LEN [NREC] = '{DEV_LEN, MBX_LEN, MEM_LEN};

    logic [127:0] rec [NREC+1];

    assign rec[0] = {64'h0, 16'h0, 16'(NREC), 8'h0, 8'h1, 16'h0};

    for (genvar g = 0; g < NREC; g++) begin : g_rec
        assign rec[g+1] = {32'h0, REC_LEN[g], REC_OFF[g], 8'h0, REC_VER[g], REC_ID[g]};
    end

    logic [SW-1:0] sel;
    assign sel = word_idx[SW:1];

    always_comb begin
        word = '0;
        if (32'(word_idx) < 2 * (NREC + 1)) begin
            word = word_idx[0] ? rec[sel][127:64] : rec[sel][63:0];
        end
    end
endmodule

// File: rtl/capwin_evt.sv
module capwin_evt #(
    parameter int unsigned NUM_LOGS = 4,
    localparam int unsigned LW = (NUM_LOGS > 1) ? $clog2(NUM_LOGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_valid,
    input  logic [LW-1:0]       upd_log,
    input  logic                upd_has,
    output logic [NUM_LOGS-1:0] status
);
    typedef struct packed {
        logic [NUM_LOGS-1:0] bits;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_valid && (32'(upd_log) < NUM_LOGS)) begin
            st_d.bits[upd_log] = upd_has;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;
endmodule

// File: rtl/capwin_top.sv
module capwin_top
    import capwin_pkg::*;
#(
    parameter int unsigned NUM_LOGS = 4,
    parameter int unsigned CAP_LEN  = 32'h80,
    parameter int unsigned DEV_OFF  = 32'h100,
    parameter int unsigned DEV_LEN  = 32'h100,
    parameter int unsigned MBX_OFF  = 32'h200,
    parameter int unsigned MBX_LEN  = 32'h200,
    parameter int unsigned MEM_OFF  = 32'h400,
    parameter int unsigned MEM_LEN  = 32'h20,
    localparam int unsigned AW = $clog2(MEM_OFF + MEM_LEN),
    localparam int unsigned LW = (NUM_LOGS > 1) ? $clog2(NUM_LOGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_be,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [63:0]   rsp_data,
    input  logic          evt_valid,
    input  logic [LW-1:0] evt_log,
    input  logic          evt_has
);
    localparam int unsigned IW = $clog2(CAP_LEN / 8);

    logic [NUM_LOGS-1:0] evt_bits;
    logic [63:0]         cap_word;
    logic [63:0]         rd_word;
    logic [31:0]         a;
    logic                aligned;
    rsp_t                rsp_d, rsp_q;

    capwin_evt #(.NUM_LOGS(NUM_LOGS)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (evt_valid),
        .upd_log   (evt_log),
        .upd_has   (evt_has),
        .status    (evt_bits)
    );

    capwin_rom #(
        .CAP_LEN (CAP_LEN),
        .DEV_OFF (DEV_OFF), .DEV_LEN (DEV_LEN),
        .MBX_OFF (MBX_OFF), .MBX_LEN (MBX_LEN),
        .MEM_OFF (MEM_OFF), .MEM_LEN (MEM_LEN)
    ) u_rom (
        .word_idx (req_addr[IW+2:3]),
        .word     (cap_word)
    );

    assign a       = 32'(req_addr);
    assign aligned = (req_addr[2:0] == 3'b000) && be_aligned(req_be);

    always_comb begin
        rd_word = '0;
        if (a < CAP_LEN) begin
            rd_word = cap_word;
        end else if (a == DEV_OFF) begin
            rd_word = 64'(evt_bits);
        end else if (a >= MEM_OFF && a < MEM_OFF + MEM_LEN) begin
            rd_word = MEMDEV_WORD;
        end
    end

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (!aligned)       rsp_d.err  = 1'b1;
            else if (!req_write) rsp_d.data = rd_word & be_mask(req_be);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_data  = rsp_q.data;
endmodule

// File: rtl/capwin_chk.sv
module capwin_chk #(
    parameter int unsigned NUM_LOGS = 4,
    parameter int unsigned LW = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic [63:0]         rsp_data,
    input logic                evt_valid,
    input logic [LW-1:0]       evt_log,
    input logic                evt_has,
    input logic [NUM_LOGS-1:0] evt_bits
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    refused_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_data == 64'h0));

    // R6
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_has) |=> evt_bits[$past(evt_log)]);

    // R6
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_has) |=> !evt_bits[$past(evt_log)]);

    // R4
    write_keeps_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !evt_valid) |=> $stable(evt_bits));
endmodule

bind capwin_top capwin_chk #(.NUM_LOGS(NUM_LOGS), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .evt_valid (evt_valid),
    .evt_log   (evt_log),
    .evt_has   (evt_has),
    .evt_bits  (evt_bits)
);

// File: tb/sim_capwin_top.sv
module sim_capwin_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_be = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_log = '0;
    logic        evt_has = 1'b0;

    always #5 clk = ~clk;

    capwin_top u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_be (req_be),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_data (rsp_data),
        .evt_valid (evt_valid), .evt_log (evt_log), .evt_has (evt_has)
    );

    typedef struct {
        logic [63:0] data;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    function automatic logic [63:0] lanes(input logic [7:0] be);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    // record k word pair from R2 field layout
    function automatic logic [63:0] rec_lo(input logic [15:0] id, input logic [7:0] ver,
                                           input logic [31:0] off);
        return {off, 8'h00, ver, id};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each response with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check(0, "R10 response with no request", {rsp_err, rsp_data}, 65'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_data == e.data && rsp_err == e.err, e.tag,
                      {rsp_err, rsp_data}, {e.err, e.data});
            end
        end
    end

    task automatic issue(input logic we, input logic [10:0] addr, input logic [7:0] be,
                         input logic [63:0] exp_data, input logic exp_err, input string tag);
        exp_t e;
        e.data = exp_data;
        e.err  = exp_err;
        e.tag  = tag;
        q.push_back(e);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = addr;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd(input logic [10:0] addr, input logic [7:0] be,
                      input logic [63:0] word, input string tag);
        issue(1'b0, addr, be, word & lanes(be), 1'b0, tag);
    endtask

    task automatic evt(input logic [1:0] lg, input logic has);
        evt_valid = 1'b1;
        evt_log   = lg;
        evt_has   = has;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    localparam logic [63:0] HDR = 64'h0000_0003_0001_0000;
    localparam logic [63:0] MDW = (64'd1 << 2) | (64'd1 << 5);

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 idle after reset", {64'h0, rsp_valid}, 65'h0);
        rd(11'h100, 8'hFF, 64'h0, "R7 event field clear at reset");

        rd(11'h000, 8'hFF, HDR, "R1 header");
        rd(11'h010, 8'hFF, rec_lo(16'h0001, 8'd2, 32'h100), "R2 device status record low");
        rd(11'h018, 8'hFF, 64'h100, "R2 device status record length");
        rd(11'h020, 8'hFF, rec_lo(16'h0002, 8'd1, 32'h200), "R2 mailbox record low");
        rd(11'h028, 8'hFF, 64'h200, "R2 mailbox record length");
        rd(11'h030, 8'hFF, rec_lo(16'h4000, 8'd1, 32'h400), "R2 memory device record low");
        rd(11'h038, 8'hFF, 64'h20, "R2 memory device record length");

        rd(11'h008, 8'hFF, 64'h0, "R3 header upper word");
        rd(11'h040, 8'hFF, 64'h0, "R3 past last record");
        rd(11'h200, 8'hFF, 64'h0, "R3 mailbox set reads zero");
        rd(11'h108, 8'hFF, 64'h0, "R3 device status spare word");
        rd(11'h7F8, 8'hFF, 64'h0, "R3 top of aperture");

        rd(11'h400, 8'hFF, MDW, "R5 memory device first word");
        rd(11'h418, 8'hFF, MDW, "R5 memory device last word");
        rd(11'h420, 8'hFF, 64'h0, "R5 R3 beyond memory device set");

        evt(2'd1, 1'b1);
        rd(11'h100, 8'hFF, 64'h2, "R6 set log 1");
        evt(2'd3, 1'b1);
        rd(11'h100, 8'hFF, 64'hA, "R6 set log 3");
        evt(2'd1, 1'b0);
        rd(11'h100, 8'hFF, 64'h8, "R6 clear log 1");

        issue(1'b1, 11'h100, 8'hFF, 64'h0, 1'b0, "R4 write response");
        rd(11'h100, 8'hFF, 64'h8, "R4 event field unchanged");
        issue(1'b1, 11'h000, 8'h0F, 64'h0, 1'b0, "R4 write to header");
        rd(11'h000, 8'hFF, HDR, "R4 header unchanged");
        issue(1'b1, 11'h400, 8'h01, 64'h0, 1'b0, "R4 write to memory device");
        rd(11'h410, 8'hFF, MDW, "R4 memory device unchanged");

        rd(11'h000, 8'h04, HDR, "R8 single lane");
        rd(11'h030, 8'hF0, rec_lo(16'h4000, 8'd1, 32'h400), "R8 upper half");
        rd(11'h010, 8'h30, rec_lo(16'h0001, 8'd2, 32'h100), "R8 lane pair 4-5");
        rd(11'h400, 8'h02, MDW, "R8 lane with zero data");

        issue(1'b0, 11'h000, 8'h06, 64'h0, 1'b1, "R9 pair on odd lane");
        issue(1'b0, 11'h000, 8'h3C, 64'h0, 1'b1, "R9 four lanes off boundary");
        issue(1'b0, 11'h000, 8'h00, 64'h0, 1'b1, "R9 no lanes");
        issue(1'b0, 11'h004, 8'h0F, 64'h0, 1'b1, "R9 address not word aligned");
        issue(1'b1, 11'h100, 8'h05, 64'h0, 1'b1, "R9 refused write");

        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 idle after last response", {64'h0, rsp_valid}, 65'h0);
        check(q.size() == 0, "R10 every request answered", 65'(q.size()), 65'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule